// File: doc/BRIEF.md
# Unaligned Access Splitter for a 16-bit Bus

This block sits between a processor port with 32-bit data and a narrow I/O bus that carries 16-bit word cycles and 8-bit byte cycles. A request gives a byte address, a size (byte, word or longword), a direction and, for stores, right-aligned store data. The block turns the request into the shortest legal series of bus cycles. Loads use word cycles only. Stores use a mix of word and byte cycles and never read before writing, because a read on an I/O bus can have side effects.

A request that crosses a longword boundary is first cut into two fragments. The low fragment starts at the request address. The high fragment starts at the next longword boundary. Each fragment holds 1 to 4 bytes and becomes one or two bus cycles. For loads, the returned words are aligned, masked, merged across the fragments and presented right-aligned in `rdata` together with a one-cycle `done` pulse. Each bus cycle completes through a valid/ready handshake.

Top module: `uasplit_top`

## Requirements
- R1: Size code 0 is a byte and forms one fragment. Size code 1 is a word: it forms one 2-byte fragment at offset 0, 1 or 2 (offset = addr[1:0]), and at offset 3 it forms single-byte fragments at addr and addr+1. Size codes 2 and 3 are a longword: at offset 0 it forms one 4-byte fragment; at any other offset bo it forms a (4-bo)-byte fragment at addr and a bo-byte fragment at the next longword boundary. All cycles of the low fragment come before those of the high fragment.
- R2: Loads use only word cycles (bus_byte=0) at even addresses. For each fragment of n bytes at address a, a load issues one word at a with bit 0 cleared when n+a[0] is at most 2. Otherwise it issues two words: first at that address, then at that address plus 2.
- R3: Stores issue these cycles for each fragment:
   - 1 byte: one byte cycle.
   - 2 bytes at an even address: one word cycle.
   - 2 bytes at an odd address: byte cycles at a and a+1.
   - 3 bytes at an even address: a word cycle at a, then a byte cycle at a+2.
   - 3 bytes at an odd address: a byte cycle at a, then a word cycle at a+1.
   - 4 bytes: word cycles at a and a+2.
- R4: At the end of a load, rdata holds the bytes at addresses a upward, little-endian and right-aligned, with all bits above the requested size equal to zero. A returned bus word carries the even byte in bits 7:0. A store leaves rdata unchanged.
- R5: The bytes a store cycle carries are taken in order from the right-aligned store data. A word cycle puts the lower-addressed byte in bits 7:0. A byte cycle puts its byte in the lane selected by bus_addr[0] (bit 0 = 0 selects bits 7:0, 1 selects bits 15:8) and puts zero in the other lane.
- R6: While bus_valid is high and bus_ready is low, bus_valid stays high and bus_addr, bus_write, bus_byte and bus_wdata hold their values.
- R7: done is high for exactly one cycle: the cycle after the handshake of the last bus cycle of a request. req_ready is high exactly when no sequence is active. bus_valid is low while done is high.
- R8: After reset, req_ready is 1, and bus_valid, done and rdata are 0.
- R9: A request presented in the cycle in which done is high is accepted and runs with the correct cycles and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Right-aligned store data |
| done | output | 1 | One-cycle pulse at the end of a request |
| rdata | output | 32 | Right-aligned load result |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Bus cycle completes this clock |
| bus_write | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | 1 = byte cycle, 0 = word cycle |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid on the handshake |

## Verification
Two things can happen in the same cycle: the done pulse that ends one request, and the acceptance of the next request. The bench's driver presents each new request on the first idle cycle, so every request after the first is offered exactly while done is high. The scoreboard then requires the full cycle list of the new request, and its load data, to come out unchanged. The bench also counts how many requests were accepted during a done cycle. The bus side withholds ready in a fixed pattern, so stalls land on the first and on the second cycle of two-cycle fragments. This shows that hold behaviour and fragment sequencing do not disturb each other.

// File: rtl/us_pkg.sv
package us_pkg;
   localparam int unsigned CPU_W = 32;
   localparam int unsigned BUS_W = 16;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LONG_ALT = 2'd3
   } size_e;

   // mask covering n bytes (n = 1..4)
   function automatic logic [CPU_W-1:0] bytes_mask(input logic [2:0] n);
      if (n >= 3'd4) return '1;
      return (CPU_W'(1) << {n, 3'b000}) - CPU_W'(1);
   endfunction
endpackage

// File: rtl/us_frag_split.sv
module us_frag_split
   import us_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size,
   output logic          two_frag,
   output logic [AW-1:0] f0_addr,
   output logic [2:0]    f0_len,
   output logic [AW-1:0] f1_addr,
   output logic [2:0]    f1_len
);
   logic [1:0] bo;
   assign bo      = addr[1:0];
   assign f0_addr = addr;
   assign f1_addr = {addr[AW-1:2], 2'b00} + AW'(4);

   always_comb begin
      two_frag = 1'b0;
      f0_len   = 3'd1;
      f1_len   = 3'd0;
      case (size_e'(size))
         SZ_BYTE: f0_len = 3'd1;
         SZ_WORD: begin
            if (bo == 2'd3) begin
               two_frag = 1'b1;
               f1_len   = 3'd1;
            end else begin
               f0_len = 3'd2;
            end
         end
         default: begin
            if (bo == 2'd0) begin
               f0_len = 3'd4;
            end else begin
               two_frag = 1'b1;
               f0_len   = 3'd4 - {1'b0, bo};
               f1_len   = {1'b0, bo};
            end
         end
      endcase
   end
endmodule

// File: rtl/us_cycle_plan.sv
module us_cycle_plan
   import us_pkg::*;
#(
   parameter int unsigned AW         = 16,
   parameter bit          LANE_STEER = 1'b1
) (
   input  logic [AW-1:0]    fa,
   input  logic [2:0]       flen,
   input  logic [CPU_W-1:0] fdata,
   input  logic             write,
   input  logic             cyc,
   output logic             two_cyc,
   output logic [AW-1:0]    c_addr,
   output logic             c_byte,
   output logic [BUS_W-1:0] c_wdata
);
   logic [AW-1:0]    even_a;
   logic [7:0]       byte_val;
   logic [BUS_W-1:0] word_val;

   assign even_a = {fa[AW-1:1], 1'b0};

   always_comb begin
      two_cyc  = 1'b0;
      c_addr   = fa;
      c_byte   = 1'b0;
      byte_val = fdata[7:0];
      word_val = fdata[15:0];
      if (!write) begin
         two_cyc = ({1'b0, flen} + {3'b000, fa[0]}) > 4'd2;
         c_addr  = cyc ? even_a + AW'(2) : even_a;
      end else begin
         case (flen)
            3'd1: c_byte = 1'b1;
            3'd2: begin
               two_cyc = fa[0];
               c_byte  = fa[0];
               if (cyc) begin
                  c_addr   = fa + AW'(1);
                  byte_val = fdata[15:8];
               end
            end
            3'd3: begin
               two_cyc = 1'b1;
               if (!fa[0]) begin
                  c_byte = cyc;
                  if (cyc) begin
                     c_addr   = fa + AW'(2);
                     byte_val = fdata[23:16];
                  end
               end else begin
                  c_byte = !cyc;
                  if (cyc) begin
                     c_addr   = fa + AW'(1);
                     word_val = fdata[23:8];
                  end
               end
            end
            default: begin
               two_cyc = 1'b1;
               if (cyc) begin
                  c_addr   = fa + AW'(2);
                  word_val = fdata[31:16];
               end
            end
         endcase
      end
   end

   generate
      if (LANE_STEER) begin : g_steer
         assign c_wdata = !write ? '0 :
                          !c_byte ? word_val :
                          c_addr[0] ? {byte_val, 8'h00} : {8'h00, byte_val};
      end else begin : g_low_lane
         assign c_wdata = !write ? '0 : !c_byte ? word_val : {8'h00, byte_val};
      end
   endgenerate
endmodule

// File: rtl/us_read_merge.sv
module us_read_merge
   import us_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  logic [AW-1:0]    fa,
   input  logic [2:0]       flen,
   input  logic             two_word,
   input  logic [BUS_W-1:0] word_first,
   input  logic [BUS_W-1:0] word_last,
   output logic [CPU_W-1:0] frag_val
);
   logic [CPU_W-1:0] lw;

   always_comb begin
      if (two_word)   lw = {word_last, word_first};
      else if (fa[1]) lw = {word_last, 16'h0000};
      else            lw = {16'h0000, word_last};
      frag_val = (lw >> {fa[1:0], 3'b000}) & bytes_mask(flen);
   end
endmodule

// File: rtl/uasplit_top.sv
module uasplit_top
   import us_pkg::*;
#(
   parameter int unsigned AW         = 16,
   parameter bit          LANE_STEER = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [1:0]     req_size,
   input  logic [AW-1:0]  req_addr,
   input  logic [31:0]    req_wdata,
   output logic           done,
   output logic [31:0]    rdata,
   output logic           bus_valid,
   input  logic           bus_ready,
   output logic           bus_write,
   output logic           bus_byte,
   output logic [AW-1:0]  bus_addr,
   output logic [15:0]    bus_wdata,
   input  logic [15:0]    bus_rdata
);
   localparam int unsigned SH_W = 6;

   generate
      if (AW < 3) begin : g_aw_bad
         $error("uasplit_top: AW must be at least 3");
      end
   endgenerate

   logic             busy, frag_idx, cyc_idx, l_write, done_q;
   logic [1:0]       l_size;
   logic [AW-1:0]    l_addr;
   logic [CPU_W-1:0] l_wdata, acc, rdata_q;
   logic [BUS_W-1:0] word0;

   logic             two_frag, two_cyc, c_byte;
   logic [AW-1:0]    f0_addr, f1_addr, cur_addr, c_addr;
   logic [2:0]       f0_len, f1_len, cur_len;
   logic [SH_W-1:0]  sh0;
   logic [CPU_W-1:0] cur_data, frag_val, merged;
   logic [BUS_W-1:0] c_wdata;
   logic             hs, last_cyc, last_frag;

   us_frag_split #(.AW(AW)) u_split (
      .addr(l_addr), .size(l_size), .two_frag(two_frag),
      .f0_addr(f0_addr), .f0_len(f0_len), .f1_addr(f1_addr), .f1_len(f1_len)
   );

   assign sh0      = {f0_len, 3'b000};
   assign cur_addr = frag_idx ? f1_addr : f0_addr;
   assign cur_len  = frag_idx ? f1_len : f0_len;
   assign cur_data = frag_idx ? (l_wdata >> sh0) : l_wdata;

   us_cycle_plan #(.AW(AW), .LANE_STEER(LANE_STEER)) u_plan (
      .fa(cur_addr), .flen(cur_len), .fdata(cur_data), .write(l_write),
      .cyc(cyc_idx), .two_cyc(two_cyc), .c_addr(c_addr), .c_byte(c_byte),
      .c_wdata(c_wdata)
   );

   us_read_merge #(.AW(AW)) u_merge (
      .fa(cur_addr), .flen(cur_len), .two_word(two_cyc),
      .word_first(word0), .word_last(bus_rdata), .frag_val(frag_val)
   );

   assign hs        = busy && bus_ready;
   assign last_cyc  = (cyc_idx == two_cyc);
   assign last_frag = (frag_idx == two_frag);
   assign merged    = acc | (frag_val << (frag_idx ? sh0 : SH_W'(0)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         frag_idx <= 1'b0;
         cyc_idx  <= 1'b0;
         l_write  <= 1'b0;
         l_size   <= 2'd0;
         l_addr   <= '0;
         l_wdata  <= '0;
         word0    <= '0;
         acc      <= '0;
         done_q   <= 1'b0;
         rdata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               busy     <= 1'b1;
               frag_idx <= 1'b0;
               cyc_idx  <= 1'b0;
               l_write  <= req_write;
               l_size   <= req_size;
               l_addr   <= req_addr;
               l_wdata  <= req_wdata;
               acc      <= '0;
            end
         end else if (hs) begin
            if (!last_cyc) begin
               word0   <= bus_rdata;
               cyc_idx <= 1'b1;
            end else begin
               acc     <= merged;
               cyc_idx <= 1'b0;
               if (last_frag) begin
                  busy   <= 1'b0;
                  done_q <= 1'b1;
                  if (!l_write) rdata_q <= merged;
               end else begin
                  frag_idx <= 1'b1;
               end
            end
         end
      end
   end

   assign req_ready = !busy;
   assign done      = done_q;
   assign rdata     = rdata_q;
   assign bus_valid = busy;
   assign bus_write = l_write;
   assign bus_byte  = c_byte;
   assign bus_addr  = c_addr;
   assign bus_wdata = c_wdata;
endmodule

// File: rtl/us_split_chk.sv
module us_split_chk #(
   parameter int unsigned AW         = 16,
   parameter bit          LANE_STEER = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          done,
   input logic          bus_valid,
   input logic          bus_ready,
   input logic          bus_write,
   input logic          bus_byte,
   input logic [AW-1:0] bus_addr,
   input logic [15:0]   bus_wdata
);
   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_write) && $stable(bus_byte) && $stable(bus_wdata));

   // R2
   read_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write |-> !bus_byte);

   // R2
   word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_byte |-> !bus_addr[0]);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready && !bus_valid);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && bus_valid);

   generate
      if (LANE_STEER) begin : g_lane
         // R5
         byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_valid && bus_write && bus_byte |->
            (bus_addr[0] ? (bus_wdata[7:0] == 8'h00) : (bus_wdata[15:8] == 8'h00)));
      end
   endgenerate
endmodule

bind uasplit_top us_split_chk #(.AW(AW), .LANE_STEER(LANE_STEER)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .done(done), .bus_valid(bus_valid), .bus_ready(bus_ready),
   .bus_write(bus_write), .bus_byte(bus_byte), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata)
);

// File: tb/uasplit_top_tb.sv
module uasplit_top_tb;
   localparam int AW = 16;

   typedef struct packed {
      logic          wr;
      logic          byt;
      logic [AW-1:0] addr;
      logic [15:0]   wd;
   } cyc_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          done;
   logic [31:0]   rdata;
   logic          bus_valid;
   logic          bus_ready = 1'b0;
   logic          bus_write;
   logic          bus_byte;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata;
   logic [15:0]   bus_rdata = '0;

   int   tests = 0;
   int   fails = 0;
   int   b2b   = 0;
   int   stall_seen = 0;
   int   rdy_cnt = 0;
   bit   expect_done = 0;
   bit   was_stalled = 0;
   cyc_t stalled_cyc;
   logic [31:0] last_rd = '0;

   cyc_t        exp_cyc[$];
   logic [32:0] exp_res[$];

   always #4 clk = ~clk;

   uasplit_top #(.AW(AW)) u_dut (.*);

   function automatic logic [7:0] mem_b(input logic [AW-1:0] x);
      return (x[7:0] * 8'd3) ^ 8'h96;
   endfunction

   function automatic logic [15:0] mem_w(input logic [AW-1:0] w);
      return {mem_b(w + AW'(1)), mem_b(w)};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic cyc_t mk(input bit wr, input bit byt, input logic [AW-1:0] a,
                               input logic [7:0] b, input logic [15:0] w);
      cyc_t c;
      c.wr = wr; c.byt = byt; c.addr = a;
      c.wd = !wr ? 16'h0 : !byt ? w : (a[0] ? {b, 8'h00} : {8'h00, b});
      return c;
   endfunction

   // expected cycles of one fragment (R2, R3, R5)
   task automatic push_frag(input bit wr, input logic [AW-1:0] a, input int n,
                            input logic [31:0] d);
      logic [AW-1:0] ea;
      ea = {a[AW-1:1], 1'b0};
      if (!wr) begin
         exp_cyc.push_back(mk(0, 0, ea, 8'h0, 16'h0));
         if (n + int'(a[0]) > 2) exp_cyc.push_back(mk(0, 0, ea + AW'(2), 8'h0, 16'h0));
      end else if (n == 1) begin
         exp_cyc.push_back(mk(1, 1, a, d[7:0], 16'h0));
      end else if (n == 2 && !a[0]) begin
         exp_cyc.push_back(mk(1, 0, a, 8'h0, d[15:0]));
      end else if (n == 2) begin
         exp_cyc.push_back(mk(1, 1, a, d[7:0], 16'h0));
         exp_cyc.push_back(mk(1, 1, a + AW'(1), d[15:8], 16'h0));
      end else if (n == 3 && !a[0]) begin
         exp_cyc.push_back(mk(1, 0, a, 8'h0, d[15:0]));
         exp_cyc.push_back(mk(1, 1, a + AW'(2), d[23:16], 16'h0));
      end else if (n == 3) begin
         exp_cyc.push_back(mk(1, 1, a, d[7:0], 16'h0));
         exp_cyc.push_back(mk(1, 0, a + AW'(1), 8'h0, d[23:8]));
      end else begin
         exp_cyc.push_back(mk(1, 0, a, 8'h0, d[15:0]));
         exp_cyc.push_back(mk(1, 0, a + AW'(2), 8'h0, d[31:16]));
      end
   endtask

   // driver: splits per R1, pushes expectations, presents request
   task automatic issue(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] d);
      int bo, nb;
      logic [31:0] v;
      logic [AW-1:0] nxt;
      bo  = int'(a[1:0]);
      nxt = {a[AW-1:2], 2'b00} + AW'(4);
      nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (done) b2b++;
      if (nb == 1) push_frag(wr, a, 1, d);
      else if (nb == 2 && bo == 3) begin
         push_frag(wr, a, 1, d);
         push_frag(wr, a + AW'(1), 1, d >> 8);
      end else if (nb == 2) push_frag(wr, a, 2, d);
      else if (bo == 0) push_frag(wr, a, 4, d);
      else begin
         push_frag(wr, a, 4 - bo, d);
         push_frag(wr, nxt, bo, d >> (8 * (4 - bo)));
      end
      v = '0;
      for (int i = 0; i < nb; i++) v |= 32'(mem_b(a + AW'(i))) << (8 * i);
      exp_res.push_back({!wr, v});
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // bus slave and scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            logic [32:0] r;
            check(expect_done, "R7 done without completed cycles", 32'(done), 32'(0));
            if (exp_res.size() == 0) check(0, "R7 unexpected done", 0, 0);
            else begin
               r = exp_res.pop_front();
               if (r[32]) last_rd = r[31:0];
               // R4: load result, or unchanged after store
               check(rdata === last_rd, r[32] ? "R4 load data" : "R4 store keeps rdata",
                     rdata, last_rd);
            end
         end else if (expect_done) begin
            check(0, "R7 done missing after last cycle", 0, 1);
         end
         expect_done = 0;
         if (bus_valid) begin
            if (was_stalled) begin
               stall_seen++;
               check({bus_write, bus_byte, bus_addr, bus_wdata} === stalled_cyc,
                     "R6 hold while stalled", 32'({bus_addr, bus_wdata}),
                     32'({stalled_cyc.addr, stalled_cyc.wd}));
            end
            rdy_cnt++;
            if (rdy_cnt % 3 != 1) begin
               cyc_t e;
               was_stalled = 0;
               bus_ready = 1'b1;
               if (exp_cyc.size() == 0) check(0, "R1 extra bus cycle", 32'(bus_addr), 0);
               else begin
                  e = exp_cyc.pop_front();
                  check(bus_write === e.wr && bus_byte === e.byt && bus_addr === e.addr,
                        "R1 R2 R3 cycle kind/address",
                        {14'h0, bus_write, bus_byte, bus_addr},
                        {14'h0, e.wr, e.byt, e.addr});
                  if (e.wr) check(bus_wdata === e.wd, "R5 write lanes",
                                  32'(bus_wdata), 32'(e.wd));
                  if (exp_cyc.size() == 0) expect_done = 1;
               end
               bus_rdata = mem_w(bus_addr);
            end else begin
               was_stalled = 1;
               stalled_cyc = {bus_write, bus_byte, bus_addr, bus_wdata};
               bus_ready = 1'b0;
            end
         end else begin
            was_stalled = 0;
            bus_ready = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8
      check(req_ready === 1'b1 && bus_valid === 1'b0 && done === 1'b0 && rdata === 32'h0,
            "R8 reset state", {req_ready, bus_valid, done, rdata[28:0]}, 32'h8000_0000);
      for (int base = 0; base < 2; base++) begin
         for (int wr = 0; wr < 2; wr++) begin
            for (int sz = 0; sz < 4; sz++) begin
               for (int off = 0; off < 4; off++) begin
                  logic [AW-1:0] a;
                  a = (base == 0 ? AW'('h1230) : AW'('hFFFC)) + AW'(off);
                  issue(wr[0], sz[1:0], a, 32'hC3A5_1E70 ^ {a, ~a});
               end
            end
         end
      end
      while (!req_ready || exp_res.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      check(exp_cyc.size() == 0, "R1 all cycles issued", exp_cyc.size(), 0);
      // R9: requests were taken during done cycles
      check(b2b > 20, "R9 accept during done", b2b, 21);
      check(stall_seen > 20, "R6 stalls exercised", stall_seen, 21);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule